// File: doc/BRIEF.md
# Word-Serial Modular Subtractor

This block computes D = (X − Y) mod N on 256-bit operands that are already reduced (X, Y < N). The three operands sit in external synchronous memories as eight 32-bit words, with word address 0 holding the least significant word. The block reads the operands one word at a time through two read-address outputs. X and Y share one address and the modulus has its own. Each memory returns the word one clock after its address is presented. The block writes the result word by word into an external result memory through a write address, a data bus and a write strobe.

Work is done in two sweeps over the words, least significant first. The first sweep, state SCAN, ripples a borrow through X − Y and keeps only the final borrow, which says whether X < Y. The second sweep, state APPLY, computes X − Y again word by word. When that flag is set, it also adds N through a separate carry chain. Each word produced in this sweep is written out. State FLUSH completes the last write, then the machine returns to IDLE.

The transitions are:
- IDLE→SCAN when `start` is high.
- SCAN→APPLY after word 7's address has been issued.
- APPLY→FLUSH after word 7's address has been issued again.
- FLUSH→IDLE unconditionally.

`ready` is high only in IDLE.

Top module: `msub_wordser`

## Requirements
- R1: After reset `ready` is 1 and `res_we` is 0, and both stay that way until `start` is seen.
- R2: Word address k carries bits [32k+31:32k] of each operand and of the result, so address 0 is the least significant word.
- R3: When X ≥ Y, the eight result words written together equal X − Y.
- R4: When X < Y, the eight result words written together equal (X − Y + N) mod 2^256.
- R5: Operand data is consumed on the cycle after its address was driven on `opnd_addr`/`mod_addr`, which matches memories with one cycle of read latency.
- R6: `ready` is 0 on the cycle after a `start` accepted in IDLE. It returns to 1 exactly 2·8+1 = 17 clock edges after the accepting edge, on the edge that follows the write of word 7.
- R7: A `start` pulse seen while the block is busy has no effect: the result, the latency and the number of writes are those of the running operation, and the block stays idle afterwards.
- R8: Each operation performs exactly eight writes, on consecutive cycles, to addresses 0,1,…,7 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins an operation when idle |
| ready | output | 1 | High while idle |
| opnd_addr | output | 3 | Read address shared by the X and Y memories |
| mod_addr | output | 3 | Read address of the modulus memory |
| x_word | input | 32 | X word returned one cycle after its address |
| y_word | input | 32 | Y word returned one cycle after its address |
| m_word | input | 32 | N word returned one cycle after its address |
| res_addr | output | 3 | Result memory write address |
| res_we | output | 1 | Result memory write strobe |
| res_data | output | 32 | Result word to be written |

## Verification
The bench uses operand pairs built to stress the carry chains:
- X = 0 with Y = N − 1, which forces the add-back across every word and must give 1. A design that drops the add-back carry between words gives a large wrong value.
- X = Y, which must give zero without an add-back. A design that adds N on a zero borrow returns N.
- A borrow that ripples out of word 0. A design that resets the borrow on each word gets word 1 wrong.

The bench also fires a start pulse in the middle of an operation. A sequencer that restarts on it would lengthen the busy time and write extra words. Finally, the bench counts cycles from the accepting edge to `ready`. This catches an off-by-one in the one-cycle read pipeline, which would also shift every written word by one address.

// File: rtl/msub_pkg.sv
package msub_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_APPLY,
        ST_FLUSH
    } msub_state_e;

endpackage

// File: rtl/msub_word.sv
// One word of the subtract chain followed by an optional add of the modulus.
module msub_word #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] x_in,
    input  logic [WORD_W-1:0] y_in,
    input  logic [WORD_W-1:0] m_in,
    input  logic              brw_in,
    input  logic              cry_in,
    input  logic              add_en,
    output logic [WORD_W-1:0] sum_out,
    output logic              brw_out,
    output logic              cry_out
);
    logic [WORD_W:0] diff_ext;
    logic [WORD_W:0] sum_ext;
    logic [WORD_W:0] addend;

    always_comb begin
        diff_ext = {1'b0, x_in} - {1'b0, y_in} - {{WORD_W{1'b0}}, brw_in};
        addend   = add_en ? {1'b0, m_in} : '0;
        sum_ext  = {1'b0, diff_ext[WORD_W-1:0]} + addend + {{WORD_W{1'b0}}, cry_in};
        brw_out  = diff_ext[WORD_W];
        cry_out  = sum_ext[WORD_W];
        sum_out  = sum_ext[WORD_W-1:0];
    end
endmodule

// File: rtl/msub_chain.sv
// Holds the borrow/carry between words and the X<Y flag between the sweeps.
module msub_chain #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cons_vld,
    input  logic              cons_pass,
    input  logic              cons_first,
    input  logic              cons_last,
    input  logic [WORD_W-1:0] x_in,
    input  logic [WORD_W-1:0] y_in,
    input  logic [WORD_W-1:0] m_in,
    output logic [WORD_W-1:0] word_out
);
    logic brw_q, cry_q, lt_q;
    logic brw_in, cry_in, brw_out, cry_out, add_en;

    always_comb begin
        brw_in = cons_first ? 1'b0 : brw_q;
        cry_in = cons_first ? 1'b0 : cry_q;
        add_en = cons_pass & lt_q;
    end

    msub_word #(.WORD_W(WORD_W)) u_word (
        .x_in    (x_in),
        .y_in    (y_in),
        .m_in    (m_in),
        .brw_in  (brw_in),
        .cry_in  (cry_in),
        .add_en  (add_en),
        .sum_out (word_out),
        .brw_out (brw_out),
        .cry_out (cry_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brw_q <= 1'b0;
            cry_q <= 1'b0;
            lt_q  <= 1'b0;
        end else if (cons_vld) begin
            brw_q <= brw_out;
            cry_q <= cry_out;
            if (!cons_pass && cons_last)
                lt_q <= brw_out;
        end
    end

    // R4: the second sweep recomputes X-Y, so its final borrow must agree
    // with the flag recorded at the end of the first sweep.
    a_r4_borrow_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_vld && cons_pass && cons_last) |-> (brw_out == lt_q))
        else $error("second-sweep borrow disagrees with recorded flag");
endmodule

// File: rtl/msub_seq.sv
// Word sequencer: issues addresses one stage ahead of the arithmetic.
module msub_seq
    import msub_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              ready,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              cons_vld,
    output logic              cons_pass,
    output logic [ADDR_W-1:0] cons_idx
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_WORDS - 1);

    msub_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              issuing;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)          state_d = ST_SCAN;
            ST_SCAN:  if (addr_q == LAST) state_d = ST_APPLY;
            ST_APPLY: if (addr_q == LAST) state_d = ST_FLUSH;
            ST_FLUSH:                     state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        issuing = (state_q == ST_SCAN) || (state_q == ST_APPLY);
        ready   = (state_q == ST_IDLE);
        rd_addr = addr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            cons_vld  <= 1'b0;
            cons_pass <= 1'b0;
            cons_idx  <= '0;
        end else begin
            if (issuing) addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
            else         addr_q <= '0;
            cons_vld  <= issuing;
            cons_pass <= (state_q == ST_APPLY);
            cons_idx  <= addr_q;
        end
    end

    // R5: the word consumed now was addressed on the previous cycle.
    a_r5_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        cons_vld |-> (cons_idx == $past(rd_addr)))
        else $error("consumed index does not match last issued address");

    // R6: ready falls right after an accepted start.
    a_r6_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> !ready)
        else $error("ready did not fall after start");

    // R6: ready returns on the edge after the last write.
    a_r6_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_vld && cons_pass && cons_idx == LAST) |=> ready)
        else $error("ready not raised after final write");

    // R1: idle persists without start.
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> (ready && !cons_vld))
        else $error("left idle without start");

    // R7: start during the first sweep does not end the operation.
    a_r7_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && start) |=> !ready)
        else $error("start while busy disturbed the sequence");

    // R8: writes walk the addresses upward on consecutive cycles.
    a_r8_write_order: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_vld && cons_pass && cons_idx != LAST) |=>
        (cons_vld && cons_pass && cons_idx == ADDR_W'($past(cons_idx) + 1'b1)))
        else $error("write addresses not consecutive");
endmodule

// File: rtl/msub_wordser.sv
module msub_wordser #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 8,
    parameter int ADDR_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              ready,
    output logic [ADDR_W-1:0] opnd_addr,
    output logic [ADDR_W-1:0] mod_addr,
    input  logic [WORD_W-1:0] x_word,
    input  logic [WORD_W-1:0] y_word,
    input  logic [WORD_W-1:0] m_word,
    output logic [ADDR_W-1:0] res_addr,
    output logic              res_we,
    output logic [WORD_W-1:0] res_data
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_WORDS - 1);

    logic [ADDR_W-1:0] rd_addr, cons_idx;
    logic              cons_vld, cons_pass;
    logic              cons_first, cons_last;

    msub_seq #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ready     (ready),
        .rd_addr   (rd_addr),
        .cons_vld  (cons_vld),
        .cons_pass (cons_pass),
        .cons_idx  (cons_idx)
    );

    always_comb begin
        cons_first = (cons_idx == '0);
        cons_last  = (cons_idx == LAST);
        opnd_addr  = rd_addr;
        mod_addr   = rd_addr;
        res_addr   = cons_idx;
        res_we     = cons_vld & cons_pass;
    end

    msub_chain #(.WORD_W(WORD_W)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .cons_vld   (cons_vld),
        .cons_pass  (cons_pass),
        .cons_first (cons_first),
        .cons_last  (cons_last),
        .x_in       (x_word),
        .y_in       (y_word),
        .m_in       (m_word),
        .word_out   (res_data)
    );

    // R8: nothing is written while idle.
    a_r8_no_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> !ready)
        else $error("write while idle");
endmodule

// File: tb/msub_wordser_test.sv
`timescale 1ns/1ps
module msub_wordser_test;
    localparam int W  = 32;
    localparam int NW = 8;
    localparam int AW = 3;
    localparam logic [255:0] MODN =
        256'hffffffff00000001000000000000000000000000ffffffffffffffffffffffff;
    localparam int NV = 7;
    // Vector table: X, Y (all below MODN).
    localparam logic [255:0] TX [NV] = '{
        256'h0123456789abcdeffedcba98765432100f1e2d3c4b5a69788796a5b4c3d2e1f0,
        256'h0000000011111111222222223333333344444444555555556666666677777777,
        256'h5a5a5a5a00000000a5a5a5a5ffffffff0000000012345678deadbeefcafef00d,
        256'h0,
        256'hffffffff00000001000000000000000000000000fffffffffffffffffffffffe,
        256'h0000000000000000000000000000000000000000000000000000000100000000,
        256'h0
    };
    localparam logic [255:0] TY [NV] = '{
        256'h0000000011111111222222223333333344444444555555556666666677777777,
        256'h0123456789abcdeffedcba98765432100f1e2d3c4b5a69788796a5b4c3d2e1f0,
        256'h5a5a5a5a00000000a5a5a5a5ffffffff0000000012345678deadbeefcafef00d,
        256'hffffffff00000001000000000000000000000000fffffffffffffffffffffffe,
        256'h0,
        256'h1,
        256'h0
    };

    logic clk = 1'b0;
    logic rst_n, start, ready, res_we;
    logic [AW-1:0] opnd_addr, mod_addr, res_addr;
    logic [W-1:0]  x_word, y_word, m_word, res_data;

    logic [W-1:0] xm [NW];
    logic [W-1:0] ym [NW];
    logic [W-1:0] mm [NW];
    logic [W-1:0] rm [NW];

    int n_chk = 0, n_bad = 0, cyc = 0;
    int wr_cnt;
    int exp_wa;
    bit order_bad;

    always #4 clk = ~clk;

    msub_wordser uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
        .opnd_addr(opnd_addr), .mod_addr(mod_addr),
        .x_word(x_word), .y_word(y_word), .m_word(m_word),
        .res_addr(res_addr), .res_we(res_we), .res_data(res_data)
    );

    always @(posedge clk) begin
        x_word <= xm[opnd_addr];
        y_word <= ym[opnd_addr];
        m_word <= mm[mod_addr];
        cyc    <= cyc + 1;
        if (rst_n && res_we) begin
            rm[res_addr] <= res_data;
            if (int'(res_addr) != exp_wa) order_bad = 1'b1;
            exp_wa = exp_wa + 1;
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [255:0] x, input logic [255:0] y);
        for (int k = 0; k < NW; k++) begin
            xm[k] = x[k*W +: W];
            ym[k] = y[k*W +: W];
            mm[k] = MODN[k*W +: W];
            rm[k] = 'x;
        end
    endtask

    // Runs one operation; busy_poke>0 pulses start that many cycles into it.
    task automatic run(input logic [255:0] x, input logic [255:0] y,
                       input int busy_poke, input string tag);
        logic [256:0] e;
        logic [255:0] got;
        int n;
        load(x, y);
        wr_cnt = 0; exp_wa = 0; order_bad = 1'b0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(ready == 1'b0, "R6 ready low after accept", 256'(ready), 256'(0));
        n = 0;
        while (!ready && n < 100) begin
            @(negedge clk);
            n++;
            if (n == busy_poke) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        chk(n == 2*NW+1, "R6 busy cycles", 256'(n), 256'(2*NW+1));
        chk(wr_cnt == NW && !order_bad, "R8 write count/order",
            256'(wr_cnt), 256'(NW));
        e = {1'b0, x} - {1'b0, y};
        if (x < y) e = e + {1'b0, MODN};
        for (int k = 0; k < NW; k++) got[k*W +: W] = rm[k];
        chk(got == e[255:0], tag, got, e[255:0]);
    endtask

    initial begin : watchdog
        wait (cyc > 100000);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [255:0] rx, ry;
        start = 1'b0;
        exp_wa = 0; wr_cnt = 0; order_bad = 1'b0;
        load('0, '0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ready == 1'b1, "R1 ready after reset", 256'(ready), 256'(1));
        chk(res_we == 1'b0 && wr_cnt == 0, "R1 no write after reset",
            256'(wr_cnt), 256'(0));

        // Table walk: R2 word layout is exercised by distinct per-word values.
        for (int v = 0; v < NV; v++)
            run(TX[v], TY[v], 0, (TX[v] >= TY[v]) ? "R2 R3 table X>=Y" : "R2 R4 table X<Y");

        // Random reduced operands (top bit cleared keeps them below MODN).
        for (int i = 0; i < 12; i++) begin
            for (int k = 0; k < NW; k++) begin
                rx[k*W +: W] = $urandom;
                ry[k*W +: W] = $urandom;
            end
            rx[255] = 1'b0; ry[255] = 1'b0;
            if (i == 3) ry = rx;
            run(rx, ry, 0, (rx >= ry) ? "R3 random" : "R4 random");
        end

        // R7: start pulses during each phase of a busy operation.
        run(TX[3], TY[3], 3,  "R7 start in first sweep");
        run(TX[0], TY[0], 12, "R7 start in second sweep");
        run(TX[1], TY[1], 16, "R7 start at last write");
        wr_cnt = 0;
        repeat (4) @(negedge clk);
        chk(ready == 1'b1 && wr_cnt == 0, "R7 stays idle after busy start",
            256'(wr_cnt), 256'(0));

        // R5: a mid-run result depends on a one-cycle memory: the add-back
        // case X=0,Y=N-1 must give exactly 1.
        run(256'h0, MODN - 256'h1, 0, "R5 R4 full add-back gives one");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule